// File: doc/BRIEF.md
# USB Low-Speed Packet Receiver

This block takes the two USB data lines of a low-speed (1.5 Mbit/s) link and turns the packets on them into bytes. The lines are first passed through a two-flop synchroniser. A bit-timing stage then produces one sample strobe per bit time. It restarts its phase counter on every line transition, so that each sample falls near the middle of a bit. A fractional accumulator stretches some bit periods by one cycle, so a bit period that is not a whole number of clock cycles is tracked on average.

The receive core looks for the start of a packet. It needs a J-to-K change followed by a second K; if a J follows instead, it goes back to looking for the next J-to-K change. If no sync is found within a bounded number of bit samples, it raises a sync error. Once in sync, it decodes NRZI, drops the stuffed bit that follows six decoded ones (the run may cross byte boundaries) and builds bytes LSB first. Each byte comes out with a one-cycle valid strobe. A single-ended zero (both lines low) at a sample ends the packet and produces a done pulse with the byte count. A packet that grows longer than the buffer size is aborted with an overflow flag.

Top module: `usb_ls_rx`

## Requirements
- R1: After reset, and while the bus stays idle (J: D+ low, D- high), rx_valid, pkt_done, err_ovf and err_sync are low and pkt_len is 0.
- R2: Sync is complete when a K sample (D+ high, D- low) that follows a J sample is itself followed by another K sample. If a J is sampled after that edge instead, the search restarts, so a longer alternating K/J preamble ending in K K still locks.
- R3: If sync has not completed by the SYNC_TO-th bit sample after the first J-to-K edge (default 16), err_sync pulses for one cycle and the block returns to idle. It then emits no byte and no done pulse.
- R4: After sync, an unchanged line level from one bit to the next decodes as 1 and a change decodes as 0. The first bit's reference level is the final sync K. Decoded bits are assembled LSB first, and each complete byte is presented on rx_byte with a one-cycle rx_valid.
- R5: The bit that follows six consecutive decoded 1s is discarded whatever its level. The run counter carries across byte boundaries.
- R6: A sample with both lines low (SE0) ends the packet. One cycle after that sample, pkt_done pulses and pkt_len holds the number of whole bytes received, which may be 0. Trailing bits that do not make a whole byte are dropped.
- R7: When byte number BUF_BYTES+1 (default 12) completes, err_ovf pulses once. No further bytes are emitted and no pulse on pkt_done marks that packet; the next packet is then received normally.
- R8: The sample point is re-aligned at every line transition and advances by 10 or 11 cycles per bit (average 10 + 2/3 by default) when the line does not change. Bits of 10 or 11 cycles with runs of up to seven equal levels are therefore decoded correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| usb_dp | input | 1 | D+ line, asynchronous |
| usb_dm | input | 1 | D- line, asynchronous |
| rx_byte | output | 8 | Received byte, valid with rx_valid |
| rx_valid | output | 1 | One-cycle strobe for rx_byte |
| pkt_done | output | 1 | One-cycle pulse at end of packet |
| pkt_len | output | $clog2(BUF_BYTES+1) | Byte count of the last completed packet |
| err_ovf | output | 1 | One-cycle pulse: packet exceeded the buffer |
| err_sync | output | 1 | One-cycle pulse: sync not found in time |

## Verification
A phase counter that drifts or misses a re-phase shows up as wrong byte values within a few bits of the first long run of equal levels. A slipped unstuff counter appears at the ports as a byte shifted by one bit at the sixth one. A sync state that is wrong either drops the whole packet or produces an err_sync pulse within SYNC_TO bit times. A wrong byte counter shows as a wrong pkt_len, or as an overflow pulse with the wrong number of bytes in front of it, right at the end of the packet.

// File: rtl/usb_ls_rx_pkg.sv
// Shared types for the low-speed receiver.
// Line state is encoded as {D+, D-}.
package usb_ls_rx_pkg;
    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_J   = 2'b01,
        LN_K   = 2'b10,
        LN_SE1 = 2'b11
    } line_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_CHECK,
        ST_RECV,
        ST_DRAIN
    } rx_state_t;
endpackage

// File: rtl/usb_ls_sync.sv
// Multi-stage synchroniser for a small bus of asynchronous inputs.
// Assumes each bit is independent; reset loads RST_VAL into every stage.
module usb_ls_sync #(
    parameter int          W       = 2,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage_q [STAGES];

    // Shift the inputs through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d_async;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/usb_ls_bitclk.sv
// Bit-timing recovery: a phase counter that restarts on every line
// transition and strobes once per bit near its middle. A fractional
// accumulator adds one cycle to some periods so that the average period is
// BIT_CYC_INT + FRAC_NUM/FRAC_DEN cycles. Assumes FRAC_NUM < FRAC_DEN.
module usb_ls_bitclk
    import usb_ls_rx_pkg::*;
#(
    parameter int BIT_CYC_INT = 10,
    parameter int FRAC_NUM    = 2,
    parameter int FRAC_DEN    = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  line_t line,
    output logic  samp_stb,
    output line_t samp_line
);
    localparam int CNT_W = $clog2(BIT_CYC_INT + 2);
    localparam int ACC_W = $clog2(FRAC_DEN + 1) + 1;
    localparam logic [CNT_W-1:0] HALF = CNT_W'(BIT_CYC_INT / 2);

    line_t            line_q;
    logic [CNT_W-1:0] cnt;
    logic [ACC_W-1:0] acc;
    logic             extra;
    logic             edge_seen;
    logic [CNT_W-1:0] last_cnt;
    logic [ACC_W-1:0] acc_sum;

    assign edge_seen = (line != line_q);
    assign last_cnt  = CNT_W'(BIT_CYC_INT - 1) + CNT_W'(extra);
    assign acc_sum   = acc + ACC_W'(FRAC_NUM);

    // Keep the previous line state so that transitions can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= LN_J;
        else        line_q <= line;
    end

    // Phase counter with re-phase on transitions and fractional stretch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            acc   <= '0;
            extra <= 1'b0;
        end else if (edge_seen) begin
            cnt <= CNT_W'(1);
        end else if (cnt >= last_cnt) begin
            cnt <= '0;
            if (acc_sum >= ACC_W'(FRAC_DEN)) begin
                acc   <= acc_sum - ACC_W'(FRAC_DEN);
                extra <= 1'b1;
            end else begin
                acc   <= acc_sum;
                extra <= 1'b0;
            end
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign samp_stb  = (cnt == HALF) && !edge_seen;
    assign samp_line = line;
endmodule

// File: rtl/usb_ls_rx_core.sv
// Packet core: works on one line sample per bit. It hunts for the sync
// (J-to-K edge followed by a second K), NRZI-decodes, removes stuffed bits
// after six ones, assembles bytes LSB first and reports end of packet,
// overflow and sync timeout. All outputs are registered pulses.
module usb_ls_rx_core
    import usb_ls_rx_pkg::*;
#(
    parameter int BUF_BYTES = 11,
    parameter int SYNC_TO   = 16,
    parameter int LEN_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_stb,
    input  line_t            samp_line,
    output logic [7:0]       rx_byte,
    output logic             rx_valid,
    output logic             pkt_done,
    output logic [LEN_W-1:0] pkt_len,
    output logic             err_ovf,
    output logic             err_sync
);
    localparam int TO_W = $clog2(SYNC_TO + 1);

    rx_state_t        state;
    line_t            prev_line;
    logic [TO_W-1:0]  tcnt;
    logic [2:0]       ones;
    logic [2:0]       bitn;
    logic [7:0]       shreg;
    logic [LEN_W-1:0] nbytes;
    logic             data_bit;
    logic             jk_edge;
    logic [7:0]       next_byte;

    assign data_bit  = (samp_line == prev_line);
    assign jk_edge   = (prev_line == LN_J) && (samp_line == LN_K);
    assign next_byte = {data_bit, shreg[7:1]};

    // Sync search, bit decode, unstuffing and byte assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            prev_line <= LN_J;
            tcnt      <= '0;
            ones      <= '0;
            bitn      <= '0;
            shreg     <= '0;
            nbytes    <= '0;
            rx_byte   <= '0;
            rx_valid  <= 1'b0;
            pkt_done  <= 1'b0;
            pkt_len   <= '0;
            err_ovf   <= 1'b0;
            err_sync  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            pkt_done <= 1'b0;
            err_ovf  <= 1'b0;
            err_sync <= 1'b0;
            if (samp_stb) begin
                prev_line <= samp_line;
                case (state)
                    ST_IDLE: begin
                        if (jk_edge) begin
                            state <= ST_CHECK;
                            tcnt  <= TO_W'(1);
                        end
                    end
                    ST_HUNT, ST_CHECK: begin
                        if (state == ST_CHECK && samp_line == LN_K) begin
                            state  <= ST_RECV;
                            ones   <= '0;
                            bitn   <= '0;
                            nbytes <= '0;
                        end else if (tcnt == TO_W'(SYNC_TO)) begin
                            err_sync <= 1'b1;
                            state    <= ST_IDLE;
                        end else if (samp_line == LN_SE0) begin
                            state <= ST_IDLE;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                            if (state == ST_CHECK)  state <= ST_HUNT;
                            else if (jk_edge)       state <= ST_CHECK;
                        end
                    end
                    ST_RECV: begin
                        if (samp_line == LN_SE0) begin
                            pkt_done <= 1'b1;
                            pkt_len  <= nbytes;
                            state    <= ST_IDLE;
                        end else if (ones == 3'd6) begin
                            ones <= '0;
                        end else begin
                            ones  <= data_bit ? ones + 1'b1 : 3'd0;
                            shreg <= next_byte;
                            bitn  <= bitn + 1'b1;
                            if (bitn == 3'd7) begin
                                if (nbytes == LEN_W'(BUF_BYTES)) begin
                                    err_ovf <= 1'b1;
                                    state   <= ST_DRAIN;
                                end else begin
                                    rx_byte  <= next_byte;
                                    rx_valid <= 1'b1;
                                    nbytes   <= nbytes + 1'b1;
                                end
                            end
                        end
                    end
                    ST_DRAIN: begin
                        if (samp_line == LN_SE0) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/usb_ls_rx.sv
// Top level of the low-speed receiver: synchroniser, bit-timing recovery
// and packet core. The data lines are asynchronous; the clock must be
// several times the bit rate (BIT_CYC_INT cycles per bit, at least 4).
module usb_ls_rx
    import usb_ls_rx_pkg::*;
#(
    parameter int BIT_CYC_INT = 10,
    parameter int FRAC_NUM    = 2,
    parameter int FRAC_DEN    = 3,
    parameter int BUF_BYTES   = 11,
    parameter int SYNC_TO     = 16,
    parameter int SYNC_STAGES = 2,
    localparam int LEN_W      = $clog2(BUF_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             usb_dp,
    input  logic             usb_dm,
    output logic [7:0]       rx_byte,
    output logic             rx_valid,
    output logic             pkt_done,
    output logic [LEN_W-1:0] pkt_len,
    output logic             err_ovf,
    output logic             err_sync
);
    logic [1:0] lines_sync;
    line_t      line_now;
    logic       samp_stb;
    line_t      samp_line;

    usb_ls_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({usb_dp, usb_dm}),
        .d_sync  (lines_sync)
    );

    assign line_now = line_t'(lines_sync);

    usb_ls_bitclk #(
        .BIT_CYC_INT (BIT_CYC_INT),
        .FRAC_NUM    (FRAC_NUM),
        .FRAC_DEN    (FRAC_DEN)
    ) u_bitclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .line      (line_now),
        .samp_stb  (samp_stb),
        .samp_line (samp_line)
    );

    usb_ls_rx_core #(
        .BUF_BYTES (BUF_BYTES),
        .SYNC_TO   (SYNC_TO),
        .LEN_W     (LEN_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp_stb  (samp_stb),
        .samp_line (samp_line),
        .rx_byte   (rx_byte),
        .rx_valid  (rx_valid),
        .pkt_done  (pkt_done),
        .pkt_len   (pkt_len),
        .err_ovf   (err_ovf),
        .err_sync  (err_sync)
    );
endmodule

// File: rtl/usb_ls_rx_chk.sv
// Assertion checker for usb_ls_rx, attached with bind. It relates the
// sample strobe from the timing stage to the events of the packet core.
module usb_ls_rx_chk #(
    parameter int BUF_BYTES = 11,
    parameter int LEN_W     = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             samp_stb,
    input logic [1:0]       samp_line,
    input logic             rx_valid,
    input logic             pkt_done,
    input logic [LEN_W-1:0] pkt_len,
    input logic             err_ovf,
    input logic             err_sync
);
    AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        samp_stb |=> !samp_stb); // R8
    AST_DONE_AFTER_SE0: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> ($past(samp_stb) && $past(samp_line) == 2'b00)); // R6
    AST_VALID_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(samp_stb)); // R4
    AST_SYNC_ERR_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_sync |-> $past(samp_stb)); // R3
    AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> (pkt_len <= LEN_W'(BUF_BYTES))); // R7
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_valid, pkt_done, err_ovf, err_sync})); // R7
    AST_NO_OVERFLOW_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        err_ovf |=> (!err_ovf && !rx_valid)); // R7
endmodule

bind usb_ls_rx usb_ls_rx_chk #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .samp_stb  (samp_stb),
    .samp_line (samp_line),
    .rx_valid  (rx_valid),
    .pkt_done  (pkt_done),
    .pkt_len   (pkt_len),
    .err_ovf   (err_ovf),
    .err_sync  (err_sync)
);

// File: tb/usb_ls_rx_bench.sv
// Scoreboard bench: driver tasks encode packets onto the lines and push
// expected bytes and lengths; a monitor pops and compares them.
module usb_ls_rx_bench;
    localparam int BUF = 11;
    localparam int LW  = $clog2(BUF + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          usb_dp = 1'b0;
    logic          usb_dm = 1'b1;
    logic [7:0]    rx_byte;
    logic          rx_valid;
    logic          pkt_done;
    logic [LW-1:0] pkt_len;
    logic          err_ovf;
    logic          err_sync;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [7:0] exp_bytes [$];
    int         exp_lens  [$];
    int         ovf_seen  = 0;
    int         sync_seen = 0;
    string      tag = "R1";

    int  phase = 0;
    bit  alt_mode = 1'b0;
    bit  level_k = 1'b0;
    int  ones = 0;
    logic [7:0] pkt [16];

    always #2 clk = ~clk;

    usb_ls_rx u_usb_ls_rx (
        .clk(clk), .rst_n(rst_n), .usb_dp(usb_dp), .usb_dm(usb_dm),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .pkt_done(pkt_done),
        .pkt_len(pkt_len), .err_ovf(err_ovf), .err_sync(err_sync)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // lvl: 0 = J, 1 = K, 2 = SE0; held for one bit time
    task automatic put_level(input int lvl);
        int len;
        if (alt_mode) len = (phase % 2 == 1) ? 10 : 11;
        else          len = (phase % 3 == 2) ? 10 : 11;
        phase++;
        @(negedge clk);
        usb_dp = (lvl == 1);
        usb_dm = (lvl == 0);
        repeat (len - 1) @(negedge clk);
    endtask

    task automatic send_sync(input int extra_pairs);
        for (int i = 0; i < 3 + extra_pairs; i++) begin
            put_level(1);
            put_level(0);
        end
        put_level(1);
        put_level(1);
        level_k = 1'b1;
        ones = 0;
    endtask

    task automatic send_bit(input bit b);
        if (b) ones++;
        else begin
            level_k = ~level_k;
            ones = 0;
        end
        put_level(level_k ? 1 : 0);
        if (ones == 6) begin
            level_k = ~level_k;
            ones = 0;
            put_level(level_k ? 1 : 0);
        end
    endtask

    task automatic send_eop();
        put_level(2);
        put_level(2);
        for (int i = 0; i < 8; i++) put_level(0);
    endtask

    task automatic send_packet(input int n, input int tail_bits);
        for (int i = 0; i < n; i++) if (i < BUF) exp_bytes.push_back(pkt[i]);
        if (n <= BUF) exp_lens.push_back(n);
        send_sync(0);
        for (int i = 0; i < n; i++)
            for (int j = 0; j < 8; j++) send_bit(pkt[i][j]);
        for (int j = 0; j < tail_bits; j++) send_bit(j[0]);
        send_eop();
    endtask

    task automatic settle(input string req);
        repeat (40) @(negedge clk);
        check(exp_bytes.size() == 0, {req, " bytes pending"}, exp_bytes.size(), 0);
        check(exp_lens.size() == 0, {req, " done pending"}, exp_lens.size(), 0);
    endtask

    // Monitor: compare outputs against the scoreboard between clock edges.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (rx_valid) begin
                if (exp_bytes.size() == 0) check(1'b0, {tag, " unexpected byte"}, rx_byte, -1);
                else begin
                    logic [7:0] e;
                    e = exp_bytes.pop_front();
                    check(rx_byte == e, {tag, " byte"}, rx_byte, e);
                end
            end
            if (pkt_done) begin
                if (exp_lens.size() == 0) check(1'b0, {tag, " unexpected done"}, pkt_len, -1);
                else begin
                    int e;
                    e = exp_lens.pop_front();
                    check(int'(pkt_len) == e, {tag, " pkt_len"}, pkt_len, e);
                end
            end
            if (err_ovf) ovf_seen++;
            if (err_sync) sync_seen++;
        end
    end

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and quiet idle bus
        tag = "R1";
        check(!rx_valid && !pkt_done && !err_ovf && !err_sync, "R1 outputs low",
              {rx_valid, pkt_done, err_ovf, err_sync}, 0);
        check(pkt_len == 0, "R1 pkt_len", pkt_len, 0);
        repeat (200) @(negedge clk);
        check(ovf_seen == 0 && sync_seen == 0, "R1 idle events", ovf_seen + sync_seen, 0);

        // R4: plain bytes, NRZI and LSB first; R6 length
        tag = "R4";
        pkt[0] = 8'hC3; pkt[1] = 8'h01; pkt[2] = 8'h80; pkt[3] = 8'h5A;
        send_packet(4, 0);
        settle("R4");

        // R5: stuffing inside a byte and across byte boundaries
        tag = "R5";
        pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'h7E;
        pkt[3] = 8'hFC; pkt[4] = 8'h01; pkt[5] = 8'h3F;
        send_packet(6, 0);
        settle("R5");

        // R2: longer alternating preamble with restarts before the K K end
        tag = "R2";
        exp_bytes.push_back(8'h12);
        exp_bytes.push_back(8'hE7);
        exp_lens.push_back(2);
        send_sync(3);
        for (int j = 0; j < 8; j++) send_bit(j == 1 || j == 4);
        for (int j = 0; j < 8; j++) send_bit(8'hE7 >> j);
        send_eop();
        settle("R2");

        // R3: alternating K/J that never ends in K K
        tag = "R3";
        for (int i = 0; i < 17; i++) put_level((i % 2 == 0) ? 1 : 0);
        for (int i = 0; i < 30; i++) put_level(0);
        check(sync_seen == 1, "R3 err_sync count", sync_seen, 1);
        settle("R3");

        // R6: trailing partial bits dropped, and an empty packet
        tag = "R6";
        pkt[0] = 8'hA5;
        send_packet(1, 3);
        settle("R6");
        send_packet(0, 0);
        settle("R6");

        // R7: overflow, then a normal packet
        tag = "R7";
        for (int i = 0; i < 13; i++) pkt[i] = 8'(8'h20 + i);
        send_packet(13, 0);
        settle("R7");
        check(ovf_seen == 1, "R7 err_ovf count", ovf_seen, 1);
        pkt[0] = 8'h99;
        send_packet(1, 0);
        settle("R7");
        check(ovf_seen == 1, "R7 no extra overflow", ovf_seen, 1);

        // R8: 11/10 cycle bits with long runs of equal level
        tag = "R8";
        alt_mode = 1'b1;
        pkt[0] = 8'hFF; pkt[1] = 8'h00; pkt[2] = 8'hAA; pkt[3] = 8'hFF; pkt[4] = 8'h3F;
        send_packet(5, 0);
        settle("R8");
        check(sync_seen == 1, "R8 no spurious sync error", sync_seen, 1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule